// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Port

This block is the slave side of a two-wire serial bus. It runs on a system clock that is much faster than the serial clock. The raw clock and data lines are synchronised and filtered before the block looks at them. It recognises start and stop conditions and answers to one fixed 7-bit address, 1101000. The write form of the address byte is D0h and the read form is D1h. Every byte the block accepts is acknowledged on the ninth clock.

Behind the bus sits a 64-entry byte space. The block does not hold that storage; it drives a pointer, a one-cycle write strobe and write data, and it takes back the byte stored at the pointer. In a write transfer, the first data byte loads the pointer and each later byte is stored at the pointer. A read transfer streams bytes from the current pointer. The pointer advances after every stored or sent data byte and wraps around at the end of the space. A transfer may carry any number of data bytes.

A power-fail input overrides everything else. While it is high the block drops any transfer in progress, returns the pointer to zero and treats the bus as if it were not there.

Top module: `twr_regport`

## Requirements
- R1: After reset the SDA pull-down enable is 0, the write strobe is 0 and the pointer output is 0.
- R2: After a START, an address byte whose upper seven bits are 1101000 is acknowledged: SDA is pulled low during the ninth clock, and bit 0 selects read (1) or write (0). Any other address byte gets no acknowledge, and later bytes are ignored until the next START.
- R3: In a write transfer, the first data byte loads the pointer from its low six bits; its upper two bits are ignored. This byte produces no write strobe.
- R4: Every later data byte in a write transfer is acknowledged. It produces exactly one single-cycle write strobe carrying the byte at the current pointer, and the pointer advances by one after the strobe.
- R5: The pointer wraps from 63 to 0, for both stored bytes and sent bytes.
- R6: In a read transfer, bytes are sent MSB first, starting from the current pointer. The pointer advances after each byte.
- R7: When the master does not acknowledge a read byte, the block releases SDA and keeps it released until the next START.
- R8: A START is accepted in any state, including a repeated START inside a transfer. It releases SDA and restarts address matching.
- R9: While power-fail is high, the transfer in progress is aborted and the pointer is held at 0. No acknowledge and no write strobe are produced.
- R10: A pulse on SCL that lasts a single system clock is rejected by the input filter and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| pwr_fail_i | input | 1 | Power-fail deselect, active high |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | 6 | Current pointer into the byte space |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Byte to store while the strobe is high |
| reg_rdata_i | input | 8 | Byte stored at reg_addr_o |

## Verification
Power-fail and the end of a data byte can reach the engine in the same system cycle. A data byte ends when the filtered SCL falls after its eighth bit, and that edge would normally trigger both a write strobe and an acknowledge. To provoke the collision, the bench raises power-fail on the same system-clock edge that lowers SCL after the eighth bit. Because the filter delays SCL, the abort is already present when the falling edge reaches the engine. The result is judged at the ports: the scoreboard must see no strobe for that byte, and a following read must return the byte stored at address 0. A second overlap comes from a repeated START that closely follows an SCL rise counted as a data bit. The bench checks that address matching restarts cleanly in that case.

// File: rtl/twr_pkg.sv
package twr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_MACK
    } twr_state_e;
endpackage

// File: rtl/twr_filter.sv
module twr_filter #(
    parameter int WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    typedef struct packed {
        logic [1:0]     sync;
        logic [WIN-1:0] win;
        logic           out;
    } flt_s;

    flt_s q, d;
    int unsigned ones;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        d.win  = {q.win[WIN-2:0], q.sync[1]};
        ones   = 0;
        for (int i = 0; i < WIN; i++) ones = ones + int'(q.win[i]);
        d.out  = (ones > WIN / 2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign filt_o = q.out;
endmodule

// File: rtl/twr_engine.sv
module twr_engine
    import twr_pkg::*;
#(
    parameter int          AW    = 6,
    parameter logic [6:0]  ADDR7 = 7'h68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          pwr_fail_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] reg_addr_o,
    output logic          reg_wr_o,
    output logic [7:0]    reg_wdata_o,
    input  logic [7:0]    reg_rdata_i
);
    localparam int BITS = 8;

    typedef struct packed {
        twr_state_e  st;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic [7:0]  tx;
        logic [AW-1:0] ptr;
        logic        rw;
        logic        first;
        logic        nack;
        logic        oe;
        logic        wr;
        logic        scl;
        logic        sda;
    } eng_s;

    eng_s q, d;
    logic rise, fall, start, stop;

    always_comb begin
        rise  = !q.scl && scl_i;
        fall  = q.scl && !scl_i;
        start = q.scl && scl_i && q.sda && !sda_i;
        stop  = q.scl && scl_i && !q.sda && sda_i;

        d     = q;
        d.wr  = 1'b0;
        d.scl = scl_i;
        d.sda = sda_i;
        if (q.wr) d.ptr = q.ptr + 1'b1;

        if (pwr_fail_i) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.ptr = '0;
            d.cnt = '0;
            d.wr  = 1'b0;
        end else if (start) begin
            d.st    = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.first = 1'b1;
        end else if (stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall && q.cnt == 4'(BITS)) begin
                        d.cnt = '0;
                        if (q.sh[7:1] == ADDR7) begin
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                            d.st = ST_AACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.tx = reg_rdata_i;
                            d.oe = !reg_rdata_i[7];
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall && q.cnt == 4'(BITS)) begin
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.st  = ST_WACK;
                        if (q.first) begin
                            d.ptr   = q.sh[AW-1:0];
                            d.first = 1'b0;
                        end else begin
                            d.wr = 1'b1;
                        end
                    end
                end
                ST_WACK: begin
                    if (fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WR;
                    end
                end
                ST_RD: begin
                    if (rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall) begin
                        if (q.cnt == 4'(BITS)) begin
                            d.oe  = 1'b0;
                            d.st  = ST_MACK;
                            d.cnt = '0;
                            d.ptr = q.ptr + 1'b1;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b0};
                            d.oe = !q.tx[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (rise) begin
                        d.nack = sda_i;
                    end else if (fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.tx = reg_rdata_i;
                            d.oe = !reg_rdata_i[7];
                            d.st = ST_RD;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.scl   <= 1'b1;
            q.sda   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign reg_addr_o  = q.ptr;
    assign reg_wr_o    = q.wr;
    assign reg_wdata_o = q.sh;

    // R9
    pf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> (!q.oe && !q.wr));
    // R9
    pf_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> (q.ptr == '0));
    // R4
    wr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr && !pwr_fail_i) |=> (q.ptr == $past(q.ptr) + 1'b1));
    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);
    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !q.oe);
endmodule

// File: rtl/twr_regport.sv
module twr_regport #(
    parameter int         AW    = 6,
    parameter int         WIN   = 3,
    parameter logic [6:0] ADDR7 = 7'h68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          pwr_fail_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] reg_addr_o,
    output logic          reg_wr_o,
    output logic [7:0]    reg_wdata_o,
    input  logic [7:0]    reg_rdata_i
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] filt;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        twr_filter #(.WIN(WIN)) i_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[g]),
            .filt_o (filt[g])
        );
    end

    twr_engine #(.AW(AW), .ADDR7(ADDR7)) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (filt[0]),
        .sda_i       (filt[1]),
        .pwr_fail_i  (pwr_fail_i),
        .sda_oe_o    (sda_oe_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wr_o    (reg_wr_o),
        .reg_wdata_o (reg_wdata_o),
        .reg_rdata_i (reg_rdata_i)
    );
endmodule

// File: tb/test_twr_regport.sv
module test_twr_regport;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pf = 1'b0;
    logic       sda_oe;
    logic [5:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sda_line;

    logic [7:0] mem   [64];
    logic [7:0] model [64];
    logic [13:0] exp_wr[$];
    logic [7:0]  exp_rd[$];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    twr_regport i_twr_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .pwr_fail_i  (pf),
        .sda_oe_o    (sda_oe),
        .reg_addr_o  (reg_addr),
        .reg_wr_o    (reg_wr),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata)
    );

    always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // write monitor: pops the scoreboard at every strobe (R4)
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R4 unexpected strobe", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [13:0] e;
                e = exp_wr.pop_front();
                check({reg_addr, reg_wdata} == e, "R4 strobe addr/data",
                      {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 3) begin
                @(negedge clk); scl_m = 1'b1; @(negedge clk); scl_m = 1'b0;
            end
            wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = !sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    // drives master ack/nack; pops expected byte and compares (R6)
    task automatic recv_check(input bit give_ack, input string tag);
        logic [7:0] b;
        logic [7:0] e;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq();
            b[i] = sda_line;
            wq(); scl_m = 1'b0; wq();
        end
        sda_m = !give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
        e = exp_rd.pop_front();
        check(b == e, tag, b, e);
    endtask

    task automatic wr_data(input logic [5:0] a, input logic [7:0] v);
        bit ack;
        exp_wr.push_back({a, v});
        model[a] = v;
        send_byte(v, 1'b0, ack);
        check(ack, "R4 data ack", ack, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < 64; i++) begin
            mem[i]   = 8'((i * 37 + 11) ^ 8'h5C);
            model[i] = 8'((i * 37 + 11) ^ 8'h5C);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_addr == 6'd0, "R1 reset",
              {sda_oe, reg_wr, reg_addr}, 0);

        // R2 foreign address is not acknowledged, following byte ignored
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        check(!ack, "R2 wrong address nack", ack, 0);
        send_byte(8'h55, 1'b0, ack);
        check(!ack, "R2 ignored after mismatch", ack, 0);
        bus_stop();

        // R3 pointer load with upper bits ignored, R4 sequential writes
        bus_start();
        send_byte(8'hD0, 1'b0, ack);
        check(ack, "R2 write address ack", ack, 1);
        send_byte(8'hC5, 1'b0, ack);
        check(ack, "R3 pointer byte ack", ack, 1);
        check(reg_addr == 6'd5, "R3 pointer from low six bits", reg_addr, 5);
        wr_data(6'd5, 8'h11);
        wr_data(6'd6, 8'h22);
        wr_data(6'd7, 8'h33);
        bus_stop();
        check(reg_addr == 6'd8, "R4 pointer advanced", reg_addr, 8);

        // R5 wrap while writing
        bus_start();
        send_byte(8'hD0, 1'b0, ack);
        send_byte(8'd62, 1'b0, ack);
        wr_data(6'd62, 8'hA1);
        wr_data(6'd63, 8'hB2);
        wr_data(6'd0, 8'hC3);
        bus_stop();
        check(reg_addr == 6'd1, "R5 write wrap", reg_addr, 1);

        // R8 repeated START, R6 read stream, R5 read wrap, R7 nack release
        bus_start();
        send_byte(8'hD0, 1'b0, ack);
        send_byte(8'd62, 1'b0, ack);
        bus_start();
        send_byte(8'hD1, 1'b0, ack);
        check(ack, "R8 repeated start read address ack", ack, 1);
        exp_rd.push_back(model[62]);
        exp_rd.push_back(model[63]);
        exp_rd.push_back(model[0]);
        recv_check(1'b1, "R6 read byte 62");
        recv_check(1'b1, "R5 read byte 63");
        recv_check(1'b0, "R5 read wrapped byte 0");
        exp_rd.push_back(8'hFF);
        recv_check(1'b0, "R7 line released after nack");
        bus_stop();

        // R10 single-cycle SCL glitch rejected
        bus_start();
        send_byte(8'hD0, 1'b0, ack);
        send_byte(8'd10, 1'b0, ack);
        exp_wr.push_back({6'd10, 8'h5A});
        model[10] = 8'h5A;
        send_byte(8'h5A, 1'b1, ack);
        check(ack, "R10 glitch byte ack", ack, 1);
        bus_stop();

        // R9 power-fail on the edge that ends a data byte
        bus_start();
        send_byte(8'hD0, 1'b0, ack);
        send_byte(8'd20, 1'b0, ack);
        wr_data(6'd20, 8'h77);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[0] ^ 1'b1;
            sda_m = (8'h88 >> i) & 1;
            wq(); scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0;
            if (i == 0) pf = 1'b1;
            wq();
        end
        sda_m = 1'b1;
        wq();
        check(reg_addr == 6'd0 && sda_oe == 1'b0, "R9 abort and pointer reset",
              {sda_oe, reg_addr}, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, 1'b0, ack);
        check(!ack, "R9 bus ignored during power-fail", ack, 0);
        bus_stop();
        pf = 1'b0;
        wq();
        bus_start();
        send_byte(8'hD1, 1'b0, ack);
        check(ack, "R9 read address after power-fail", ack, 1);
        exp_rd.push_back(model[0]);
        recv_check(1'b0, "R9 read restarts at 0");
        bus_stop();

        repeat (20) @(negedge clk);
        check(exp_wr.size() == 0, "R4 all expected strobes seen", exp_wr.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule